// File: doc/BRIEF.md
# Embedded CPU halt and status controller

This block sits beside a small embedded processor core and gives a host bus control over when the core runs. The host writes a mode register and reads a status register through a single-cycle register port. The controller watches the core's instruction-fetch and data-reference addresses and four FIFO overflow strobes from the memory interface. When a halt condition occurs, it latches the cause in a status bit and raises `halt_o` to the core.

Page-zero address halts are optional, and each is enabled by its own mode bit. FIFO overflow halts cannot be turned off. Every latched cause stays set until software writes a 1 to its status bit. A single-step command lets the core advance for one clock. After that clock the core halts again if any cause is still latched. A separate command sends a one-cycle reset pulse to the core alone.

The mode register also drives the core's write-post depth select. The status register reflects two live informational inputs: instruction-fetch stall and blocking data-cache miss.

Top module: `cpu_halt_ctrl`

## Requirements
- R1: After reset, `halt_o`, `core_rst_o`, `step_o` and `wpost_multi_o` are 0, and both the mode and status registers read 0 while the stall and miss inputs are low.
- R2: A mode write with bit 0 set makes `core_rst_o` high for exactly the one cycle after the write. Mode bit 0 always reads 0, and neither the latched causes nor the other mode bits change because of the pulse.
- R3: A mode write with bit 1 set makes `step_o` high for the one cycle after the write, and `halt_o` is 0 in that cycle. In the next cycle `halt_o` is 1 if any cause is still latched and 0 otherwise.
- R4: While mode bit 2 is 1, a data reference to an address below 256 sets status bit 3 and raises `halt_o` on the next cycle. A data reference at address 256 or above, or one made with bit 2 at 0, has no effect.
- R5: While mode bit 3 is 1, an instruction fetch from an address below 256 sets status bit 4 and raises `halt_o`. A fetch at address 256 or above, or one made with bit 3 at 0, has no effect.
- R6: `wdog_i` clears mode bits 2 and 3 on the next cycle and leaves mode bit 4 unchanged.
- R7: Mode bit 4 resets to 0, reads back as written, and drives `wpost_multi_o` (1 means several posted writes are absorbed, 0 means one).
- R8: Overflow strobes `fifo_ovf_i[0..3]` (outstanding write, outstanding read, data/bytemask, request) set status bits 27, 28, 29 and 30 respectively. Each one raises `halt_o` whatever the mode bits hold.
- R9: A status write clears each cause bit written with 1 and leaves the bits written with 0 unchanged. `halt_o` falls only once every latched cause is clear.
- R10: If a cause event and a write of 1 to the same status bit occur in the same cycle, the bit stays set.
- R11: Status bit 31 follows `blk_miss_i` and bit 15 follows `fetch_stall_i`, both live. Bits 26:16 and the other unlisted bits read 0, and status writes do not affect any of these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects mode, 1 selects status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| ifetch_valid_i | input | 1 | Core issues an instruction fetch |
| ifetch_addr_i | input | ADDR_W | Fetch address |
| dref_valid_i | input | 1 | Core issues a data reference |
| dref_addr_i | input | ADDR_W | Data reference address |
| fifo_ovf_i | input | 4 | FIFO overflow strobes |
| fetch_stall_i | input | 1 | Live instruction-fetch stall |
| blk_miss_i | input | 1 | Live blocking data-cache miss |
| wdog_i | input | 1 | Watchdog interrupt |
| halt_o | output | 1 | Halt request to the core |
| step_o | output | 1 | One-cycle advance pulse |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| wpost_multi_o | output | 1 | Write-post depth select |

## Verification
A cause bit that is lost or stuck shows up at `halt_o` one cycle after the event or after the clearing write, and shows up in the status read in the same cycle. The bench sweeps addresses on both sides of the 256-byte boundary, with each enable both on and off. It also walks each overflow strobe in turn. A wrong step or reset pulse width is visible within two cycles of the mode write, because `step_o`, `core_rst_o` and the re-raised `halt_o` are sampled in each of those cycles.

// File: rtl/cpu_halt_pkg.sv
package cpu_halt_pkg;
  localparam int NUM_OVF   = 4;
  localparam int NUM_CAUSE = NUM_OVF + 2;
  localparam int CI_DREF   = 0;
  localparam int CI_IFETCH = 1;
  localparam int CI_OVF    = 2;

  localparam int MB_CORE_RST = 0;
  localparam int MB_STEP     = 1;
  localparam int MB_EN_DREF  = 2;
  localparam int MB_EN_IFET  = 3;
  localparam int MB_WPOST    = 4;

  localparam int SB_DREF   = 3;
  localparam int SB_IFETCH = 4;
  localparam int SB_STALL  = 15;
  localparam int SB_OVF_LO = 27;
  localparam int SB_MISS   = 31;

  typedef struct packed {
    logic wpost_multi;
    logic en_ifetch;
    logic en_dref;
  } mode_t;
endpackage

// File: rtl/halt_mode_reg.sv
module halt_mode_reg
  import cpu_halt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [4:0] wdata_i,
  input  logic       wdog_i,
  output mode_t      mode_o,
  output logic       core_rst_o,
  output logic       step_o
);
  mode_t mode_q;
  logic  core_rst_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      core_rst_q <= 1'b0;
      step_q     <= 1'b0;
    end else begin
      core_rst_q <= wr_i & wdata_i[MB_CORE_RST];
      step_q     <= wr_i & wdata_i[MB_STEP];
      if (wr_i) begin
        mode_q.en_dref     <= wdata_i[MB_EN_DREF];
        mode_q.en_ifetch   <= wdata_i[MB_EN_IFET];
        mode_q.wpost_multi <= wdata_i[MB_WPOST];
      end
      // watchdog overrides a coincident write
      if (wdog_i) begin
        mode_q.en_dref   <= 1'b0;
        mode_q.en_ifetch <= 1'b0;
      end
    end
  end

  assign mode_o     = mode_q;
  assign core_rst_o = core_rst_q;
  assign step_o     = step_q;

  assert_wdog_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_i |=> (!mode_o.en_dref && !mode_o.en_ifetch));
endmodule

// File: rtl/halt_cause_bank.sv
module halt_cause_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar k = 0; k < N; k++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[k] <= 1'b0;
      else         q[k] <= set_i[k] | (q[k] & ~clr_i[k]);
    end

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
  end

  assign q_o = q;
endmodule

// File: rtl/cpu_halt_ctrl.sv
module cpu_halt_ctrl
  import cpu_halt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ifetch_valid_i,
  input  logic [ADDR_W-1:0] ifetch_addr_i,
  input  logic              dref_valid_i,
  input  logic [ADDR_W-1:0] dref_addr_i,
  input  logic [3:0]        fifo_ovf_i,
  input  logic              fetch_stall_i,
  input  logic              blk_miss_i,
  input  logic              wdog_i,
  output logic              halt_o,
  output logic              step_o,
  output logic              core_rst_o,
  output logic              wpost_multi_o
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  mode_t                mode;
  logic                 mode_wr, stat_wr;
  logic                 dref_hit, ifetch_hit;
  logic [NUM_CAUSE-1:0] cause_set, cause_clr, cause_q;
  logic [31:0]          status_rd;

  assign mode_wr = reg_we_i & ~reg_sel_i;
  assign stat_wr = reg_we_i &  reg_sel_i;

  halt_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mode_wr),
    .wdata_i    (reg_wdata_i[4:0]),
    .wdog_i     (wdog_i),
    .mode_o     (mode),
    .core_rst_o (core_rst_o),
    .step_o     (step_o)
  );

  assign dref_hit   = mode.en_dref   & dref_valid_i
                    & (dref_addr_i[ADDR_W-1:PAGE_BITS] == HI_W'(0));
  assign ifetch_hit = mode.en_ifetch & ifetch_valid_i
                    & (ifetch_addr_i[ADDR_W-1:PAGE_BITS] == HI_W'(0));

  always_comb begin
    cause_set = '0;
    cause_set[CI_DREF]   = dref_hit;
    cause_set[CI_IFETCH] = ifetch_hit;
    cause_set[CI_OVF +: NUM_OVF] = fifo_ovf_i;
    cause_clr = '0;
    if (stat_wr) begin
      cause_clr[CI_DREF]   = reg_wdata_i[SB_DREF];
      cause_clr[CI_IFETCH] = reg_wdata_i[SB_IFETCH];
      cause_clr[CI_OVF +: NUM_OVF] = reg_wdata_i[SB_OVF_LO +: NUM_OVF];
    end
  end

  halt_cause_bank #(.N(NUM_CAUSE)) u_causes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cause_set),
    .clr_i  (cause_clr),
    .q_o    (cause_q)
  );

  // step cycle lets the core advance; halt re-evaluates afterwards
  assign halt_o        = (|cause_q) & ~step_o;
  assign wpost_multi_o = mode.wpost_multi;

  always_comb begin
    status_rd = '0;
    status_rd[SB_MISS]   = blk_miss_i;
    status_rd[SB_OVF_LO +: NUM_OVF] = cause_q[CI_OVF +: NUM_OVF];
    status_rd[SB_STALL]  = fetch_stall_i;
    status_rd[SB_IFETCH] = cause_q[CI_IFETCH];
    status_rd[SB_DREF]   = cause_q[CI_DREF];
  end

  assign reg_rdata_o = reg_sel_i ? status_rd
                                 : {27'b0, mode.wpost_multi, mode.en_ifetch, mode.en_dref, 2'b00};

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i[31], reg_wdata_i[26:5],
                         dref_addr_i[PAGE_BITS-1:0], ifetch_addr_i[PAGE_BITS-1:0]};

  assert_core_rst_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> $past(reg_we_i && !reg_sel_i && reg_wdata_i[MB_CORE_RST]));

  assert_step_masks_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !halt_o);

  assert_ovf_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_ovf_i) |=> (halt_o || step_o));

  assert_halt_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> (step_o || $past(reg_we_i && reg_sel_i)));
endmodule

// File: tb/cpu_halt_ctrl_bench.sv
`timescale 1ns/100ps
module cpu_halt_ctrl_bench;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0, reg_rdata_o;
  logic          ifetch_valid_i = 1'b0, dref_valid_i = 1'b0;
  logic [AW-1:0] ifetch_addr_i = '0, dref_addr_i = '0;
  logic [3:0]    fifo_ovf_i = '0;
  logic          fetch_stall_i = 1'b0, blk_miss_i = 1'b0, wdog_i = 1'b0;
  logic          halt_o, step_o, core_rst_o, wpost_multi_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cpu_halt_ctrl #(.ADDR_W(AW), .PAGE_BITS(8)) u_cpu_halt_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse_dref(logic [AW-1:0] a);
    @(negedge clk_i); dref_valid_i = 1'b1; dref_addr_i = a;
    @(negedge clk_i); dref_valid_i = 1'b0;
  endtask

  task automatic pulse_ifetch(logic [AW-1:0] a);
    @(negedge clk_i); ifetch_valid_i = 1'b1; ifetch_addr_i = a;
    @(negedge clk_i); ifetch_valid_i = 1'b0;
  endtask

  task automatic pulse_ovf(logic [3:0] v);
    @(negedge clk_i); fifo_ovf_i = v;
    @(negedge clk_i); fifo_ovf_i = '0;
  endtask

  initial begin
    logic [31:0] r;
    logic [AW-1:0] addrs [8];
    addrs = '{16'h0000, 16'h0001, 16'h0080, 16'h00FF, 16'h0100, 16'h0101, 16'h01FF, 16'hFFFF};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 halt", halt_o, 0);
    chk("R1 core_rst", core_rst_o, 0);
    chk("R1 step", step_o, 0);
    chk("R1 wpost", wpost_multi_o, 0);
    rd(0, r); chk("R1 mode", r, 0);
    rd(1, r); chk("R1 status", r, 0);

    // R7 write-post select
    wr(0, 32'h10);
    chk("R7 wpost set", wpost_multi_o, 1);
    rd(0, r); chk("R7 mode readback", r, 32'h10);
    wr(0, 32'h0);
    chk("R7 wpost clr", wpost_multi_o, 0);

    // R4 data halt sweep
    for (int en = 0; en < 2; en++) begin
      for (int i = 0; i < 8; i++) begin
        logic hit;
        hit = (en == 1) && (addrs[i] < 256);
        wr(0, en ? 32'h4 : 32'h0);
        pulse_dref(addrs[i]);
        pulse_ifetch(addrs[i]);
        rd(1, r); chk("R4 dref status", r, hit ? 32'h8 : 32'h0);
        chk("R4 dref halt", halt_o, hit);
        wr(1, 32'h8);
        chk("R4 cleared", halt_o, 0);
      end
    end

    // R5 ifetch halt sweep
    for (int en = 0; en < 2; en++) begin
      for (int i = 0; i < 8; i++) begin
        logic hit;
        hit = (en == 1) && (addrs[i] < 256);
        wr(0, en ? 32'h8 : 32'h0);
        pulse_ifetch(addrs[i]);
        pulse_dref(addrs[i]);
        rd(1, r); chk("R5 ifetch status", r, hit ? 32'h10 : 32'h0);
        chk("R5 ifetch halt", halt_o, hit);
        wr(1, 32'h10);
        chk("R5 cleared", halt_o, 0);
      end
    end
    wr(0, 32'h0);

    // R8 overflow mapping; R9 write-zero ignored then clear
    for (int k = 0; k < 4; k++) begin
      pulse_ovf(4'(1 << k));
      rd(1, r); chk("R8 ovf status", r, 32'(1) << (27 + k));
      chk("R8 ovf halt", halt_o, 1);
      wr(1, 32'h0);
      rd(1, r); chk("R9 zero write keeps", r, 32'(1) << (27 + k));
      wr(1, 32'(1) << (27 + k));
      rd(1, r); chk("R9 cleared", r, 0);
      chk("R9 halt low", halt_o, 0);
    end

    // R9 halt holds until all causes cleared
    pulse_ovf(4'b0101);
    wr(1, 32'h0800_0000);
    chk("R9 partial clear halt", halt_o, 1);
    rd(1, r); chk("R9 partial status", r, 32'h2000_0000);
    wr(1, 32'h2000_0000);
    chk("R9 full clear halt", halt_o, 0);

    // R10 set wins over clear
    @(negedge clk_i);
    fifo_ovf_i = 4'b0001; reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 32'h0800_0000;
    @(negedge clk_i);
    fifo_ovf_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
    rd(1, r); chk("R10 set wins", r, 32'h0800_0000);
    chk("R10 halt", halt_o, 1);

    // R3 step with cause latched
    wr(0, 32'h2);
    chk("R3 step pulse", step_o, 1);
    chk("R3 halt masked", halt_o, 0);
    @(negedge clk_i);
    chk("R3 step ends", step_o, 0);
    chk("R3 halt again", halt_o, 1);
    wr(1, 32'h0800_0000);
    wr(0, 32'h2);
    chk("R3 step no cause", step_o, 1);
    @(negedge clk_i);
    chk("R3 resume", halt_o, 0);

    // R2 core reset pulse, other state kept
    pulse_ovf(4'b1000);
    wr(0, 32'h1D);
    chk("R2 rst pulse", core_rst_o, 1);
    rd(0, r); chk("R2 mode bit0 reads 0", r, 32'h1C);
    @(negedge clk_i);
    chk("R2 rst one cycle", core_rst_o, 0);
    rd(1, r); chk("R2 cause kept", r, 32'h4000_0000);
    chk("R2 halt kept", halt_o, 1);
    wr(1, 32'h4000_0000);

    // R6 watchdog
    @(negedge clk_i); wdog_i = 1'b1;
    @(negedge clk_i); wdog_i = 1'b0;
    rd(0, r); chk("R6 enables cleared", r, 32'h10);
    chk("R6 wpost kept", wpost_multi_o, 1);

    // R11 live read-only bits
    fetch_stall_i = 1'b1; blk_miss_i = 1'b1;
    rd(1, r); chk("R11 live bits", r, 32'h8000_8000);
    wr(1, 32'hFFFF_FFFF);
    rd(1, r); chk("R11 write ignored", r, 32'h8000_8000);
    chk("R11 no halt", halt_o, 0);
    fetch_stall_i = 1'b0; blk_miss_i = 1'b0;
    rd(1, r); chk("R11 live low", r, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule